// File: doc/BRIEF.md
# Serial Byte Transmitter with Register Window

This block is a small transmit-only serial port. It sits on a simple 32-bit word register bus, takes bytes written by software into an eight-entry queue, and sends each one on a single output line. Each byte goes out as a frame: a low start bit, the data bits least significant first, and a high stop bit. The line rests high between frames. The bit rate is set by a divisor register. A single global enable bit gates the whole block. Line control selects seven or eight data bits. A modem-control bit drives an active-low request-to-send pin.

Software brings the port up in a fixed order. It sets the global enable, clears interrupt enables and the transmit/receive enables, and picks the data width and the divisor. It then turns the transmitter on. To send, it polls the "queue has space" status bit and writes the byte to the data register. The transmitter is a four-state machine: **IDLE**, **START**, **DATA** and **STOP**. The transitions are:

- IDLE→START (*launch*): the transmitter is enabled and the queue is not empty. The byte is popped and latched.
- START→DATA (*start done*): eight baud ticks have elapsed.
- DATA→DATA (*next bit*): eight ticks have elapsed and bits remain.
- DATA→STOP (*last bit*): eight ticks have elapsed on the final data bit.
- STOP→IDLE (*frame done*): eight ticks have elapsed.

While the global enable is clear, the state, the baud counter and every register except the enable hold still.

Top module: `aux_serial_tx`

## Requirements
- R1: Every bit on `tx_o` lasts exactly 8 × (D + 1) clock cycles, where D is bits [15:0] of the divisor register at offset 0x68. That register reads back at the same offset.
- R2: A frame is one low start bit, the data bits LSB first, and one high stop bit. `tx_o` is high whenever the transmitter is idle.
- R3: Bit 0 of the line-control register (offset 0x4C) selects the width: set gives 8 data bits, clear gives 7 (bit 7 of the byte is not sent). Bit 1 is accepted on write, has no effect, and reads back as 0.
- R4: Bit 1 of the modem-control register (offset 0x50) drives `rts_n_o`: low while the bit is set, high while it is clear. The pin is high after reset.
- R5: The status register (offset 0x54) has two bits. Bit 5 reads 1 while the queue can take another byte. Bit 6 reads 1 only when the queue and the shifter are both empty. All other bits read 0.
- R6: Bytes written to offset 0x40 enter an 8-entry queue and are sent in write order. A write while the queue is full is dropped without any error indication. Reads of offset 0x40 return 0.
- R7: The control register (offset 0x60) reads back bits [1:0]. Bit 1 enables the transmitter, and a new frame starts only while it is set. Bit 0 (receive enable) is stored and has no other effect.
- R8: Bit 0 of the enables register (offset 0x04) turns the block on. While it is clear: writes to other offsets are ignored, reads of other offsets return 0, and a frame in progress freezes with `tx_o` held.
- R9: The interrupt-enable register (offset 0x44) stores bits [1:0]. The identify register (offset 0x48) is read-only, and writes to it change nothing. It reads 0xC2 while interrupt-enable bit 1 is set and the queue is empty, and 0xC1 otherwise.
- R10: After reset the block is off: `tx_o` is high, the divisor is 0, and all control registers are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe, one cycle per write |
| addr_i | input | 8 | Byte offset of the register accessed |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| tx_o | output | 1 | Serial transmit line, idles high |
| rts_n_o | output | 1 | Request-to-send, active low |

## Verification
Two functions can act in the same cycle: queue writes from the bus, and the pop done by the launch transition. The bench provokes this by filling the queue while the transmitter is disabled, then enabling it. Bytes are then written while frames are already in flight.

Each case is judged at the ports. The serial line is decoded at mid-bit for every frame, and the order and content are compared with the bytes written. A ninth write to a full queue must produce no frame. Bit periods are measured across a sweep of divisors. The global enable is also dropped in the middle of a frame to show that the line holds still.

// File: rtl/aux_tx_pkg.sv
package aux_tx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP
    } tx_state_e;

    localparam int OVERSAMPLE = 8;

    localparam logic [7:0] OFF_ENABLES = 8'h04;
    localparam logic [7:0] OFF_IO      = 8'h40;
    localparam logic [7:0] OFF_IER     = 8'h44;
    localparam logic [7:0] OFF_IIR     = 8'h48;
    localparam logic [7:0] OFF_LCR     = 8'h4C;
    localparam logic [7:0] OFF_MCR     = 8'h50;
    localparam logic [7:0] OFF_LSR     = 8'h54;
    localparam logic [7:0] OFF_CNTL    = 8'h60;
    localparam logic [7:0] OFF_BAUD    = 8'h68;
endpackage

// File: rtl/aux_tx_baud.sv
module aux_tx_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             idle_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (idle_i) begin
            cnt_q <= '0;
        end else if (en_i) begin
            cnt_q <= (cnt_q == div_i) ? '0 : cnt_q + 1'b1;
        end
    end

    assign tick_o = en_i && !idle_i && (cnt_q == div_i);
endmodule

// File: rtl/aux_tx_fifo.sv
module aux_tx_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic             pop_i,
    output logic [WIDTH-1:0] rdata_o,
    output logic             full_o,
    output logic             empty_o
);
    localparam int AW = $clog2(DEPTH);

    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [AW:0]      wr_q, rd_q;
    logic             do_push;

    assign full_o  = (wr_q[AW] != rd_q[AW]) && (wr_q[AW-1:0] == rd_q[AW-1:0]);
    assign empty_o = (wr_q == rd_q);
    assign do_push = push_i && !full_o;
    assign rdata_o = mem_q[rd_q[AW-1:0]];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q <= '0;
            rd_q <= '0;
        end else begin
            if (do_push) wr_q <= wr_q + 1'b1;
            if (pop_i && !empty_o) rd_q <= rd_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[wr_q[AW-1:0]] <= wdata_i;
    end
endmodule

// File: rtl/aux_tx_shifter.sv
module aux_tx_shifter
    import aux_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              go_i,
    input  logic              empty_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              wide_i,
    input  logic              tick_i,
    output logic              pop_o,
    output logic              idle_o,
    output logic              tx_o
);
    localparam int SUB_W = $clog2(OVERSAMPLE);
    localparam int IDX_W = $clog2(DATA_W);

    tx_state_e         state_q, state_d;
    logic [SUB_W-1:0]  sub_q;
    logic [IDX_W-1:0]  idx_q, last_q;
    logic [DATA_W-1:0] sh_q;
    logic              slot_end;

    assign slot_end = tick_i && (sub_q == SUB_W'(OVERSAMPLE - 1));

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (en_i) begin
            unique case (state_q)
                ST_IDLE:  if (go_i && !empty_i)              state_d = ST_START;
                ST_START: if (slot_end)                      state_d = ST_DATA;
                ST_DATA:  if (slot_end && idx_q == last_q)   state_d = ST_STOP;
                ST_STOP:  if (slot_end)                      state_d = ST_IDLE;
            endcase
        end
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sub_q   <= '0;
            idx_q   <= '0;
            last_q  <= '0;
            sh_q    <= '0;
        end else if (en_i) begin
            state_q <= state_d;
            if (state_q == ST_IDLE)  sub_q <= '0;
            else if (tick_i)         sub_q <= sub_q + 1'b1;
            if (state_q == ST_IDLE && state_d == ST_START) begin
                sh_q   <= data_i;
                idx_q  <= '0;
                last_q <= wide_i ? IDX_W'(DATA_W - 1) : IDX_W'(DATA_W - 2);
            end else if (state_q == ST_DATA && slot_end) begin
                sh_q  <= sh_q >> 1;
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        pop_o  = (state_q == ST_IDLE) && (state_d == ST_START);
        idle_o = (state_q == ST_IDLE);
        unique case (state_q)
            ST_START: tx_o = 1'b0;
            ST_DATA:  tx_o = sh_q[0];
            default:  tx_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/aux_serial_tx.sv
module aux_serial_tx
    import aux_tx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int BUS_W      = 32,
    parameter int BAUD_W     = 16,
    parameter int FIFO_DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [7:0]       addr_i,
    input  logic [BUS_W-1:0] wdata_i,
    output logic [BUS_W-1:0] rdata_o,
    output logic             tx_o,
    output logic             rts_n_o
);
    logic              uart_on;
    logic [1:0]        ier_q;
    logic              lcr_wide_q;
    logic              mcr_rts_q;
    logic [1:0]        cntl_q;
    logic [BAUD_W-1:0] baud_q;
    logic              tx_en;

    logic              wr_hit, push_req, pop;
    logic              fifo_full, fifo_empty, fsm_idle, tick;
    logic [DATA_W-1:0] fifo_data;

    assign wr_hit   = wr_en_i && uart_on;
    assign push_req = wr_hit && (addr_i == OFF_IO);
    assign tx_en    = cntl_q[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            uart_on    <= 1'b0;
            ier_q      <= '0;
            lcr_wide_q <= 1'b0;
            mcr_rts_q  <= 1'b0;
            cntl_q     <= '0;
            baud_q     <= '0;
        end else begin
            if (wr_en_i && addr_i == OFF_ENABLES) uart_on <= wdata_i[0];
            if (wr_hit) begin
                unique case (addr_i)
                    OFF_IER:  ier_q      <= wdata_i[1:0];
                    OFF_LCR:  lcr_wide_q <= wdata_i[0];
                    OFF_MCR:  mcr_rts_q  <= wdata_i[1];
                    OFF_CNTL: cntl_q     <= wdata_i[1:0];
                    OFF_BAUD: baud_q     <= wdata_i[BAUD_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == OFF_ENABLES) begin
            rdata_o[0] = uart_on;
        end else if (uart_on) begin
            unique case (addr_i)
                OFF_IER:  rdata_o[1:0] = ier_q;
                OFF_IIR:  rdata_o[7:0] = (ier_q[1] && fifo_empty) ? 8'hC2 : 8'hC1;
                OFF_LCR:  rdata_o[0]   = lcr_wide_q;
                OFF_MCR:  rdata_o[1]   = mcr_rts_q;
                OFF_LSR:  begin
                    rdata_o[5] = !fifo_full;
                    rdata_o[6] = fifo_empty && fsm_idle;
                end
                OFF_CNTL: rdata_o[1:0] = cntl_q;
                OFF_BAUD: rdata_o[BAUD_W-1:0] = baud_q;
                default: ;
            endcase
        end
    end

    assign rts_n_o = !mcr_rts_q;

    aux_tx_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push_req),
        .wdata_i (wdata_i[DATA_W-1:0]),
        .pop_i   (pop),
        .rdata_o (fifo_data),
        .full_o  (fifo_full),
        .empty_o (fifo_empty)
    );

    aux_tx_baud #(.DIV_W(BAUD_W)) u_baud (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (uart_on),
        .idle_i (fsm_idle),
        .div_i  (baud_q),
        .tick_o (tick)
    );

    aux_tx_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (uart_on),
        .go_i    (tx_en),
        .empty_i (fifo_empty),
        .data_i  (fifo_data),
        .wide_i  (lcr_wide_q),
        .tick_i  (tick),
        .pop_o   (pop),
        .idle_o  (fsm_idle),
        .tx_o    (tx_o)
    );
endmodule

// File: rtl/aux_serial_tx_chk.sv
module aux_serial_tx_chk
    import aux_tx_pkg::*;
#(
    parameter int BUS_W  = 32,
    parameter int BAUD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en_i,
    input logic [7:0]        addr_i,
    input logic [BUS_W-1:0]  wdata_i,
    input logic              tx_o,
    input logic              rts_n_o,
    input logic              uart_on,
    input logic              fsm_idle,
    input logic              fifo_full,
    input logic              push_req,
    input logic              pop,
    input logic [BAUD_W-1:0] baud_q,
    input logic              tx_en
);
    assert_rts_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && uart_on && addr_i == OFF_MCR) |=> (rts_n_o == !$past(wdata_i[1])));

    assert_drop_when_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && fifo_full && !pop) |=> fifo_full);

    assert_idle_line_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_idle |-> tx_o);

    assert_frozen_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !uart_on |=> ($stable(tx_o) && $stable(fsm_idle)));

    assert_divisor_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !uart_on |=> $stable(baud_q));

    assert_no_launch_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_idle && !tx_en) |=> fsm_idle);
endmodule

bind aux_serial_tx aux_serial_tx_chk #(.BUS_W(BUS_W), .BAUD_W(BAUD_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .tx_o     (tx_o),
    .rts_n_o  (rts_n_o),
    .uart_on  (uart_on),
    .fsm_idle (fsm_idle),
    .fifo_full(fifo_full),
    .push_req (push_req),
    .pop      (pop),
    .baud_q   (baud_q),
    .tx_en    (tx_en)
);

// File: tb/aux_serial_tx_tb_top.sv
module aux_serial_tx_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [7:0]  addr_i = '0;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o;
    logic        tx_o, rts_n_o;

    int n_checks = 0;
    int n_errors = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    aux_serial_tx dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .rdata_o(rdata_o), .tx_o(tx_o), .rts_n_o(rts_n_o)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            n_errors++;
            $display("FAIL watchdog: run hung, actual cycle %0d expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; addr_i = a; wdata_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr_i = a;
        #1 d = rdata_o;
    endtask

    task automatic wait_low();
        int t = 0;
        while (tx_o !== 1'b0 && t < 20000) begin @(negedge clk); t++; end
    endtask

    // decode one frame: returns byte and whether start/stop were right
    task automatic rx_frame(input int nbits, input int per, output logic [7:0] b, output bit framed);
        framed = 1'b1;
        b = '0;
        wait_low();
        repeat (per / 2) @(negedge clk);
        if (tx_o !== 1'b0) framed = 1'b0;
        for (int k = 0; k < nbits; k++) begin
            repeat (per) @(negedge clk);
            b[k] = tx_o;
        end
        repeat (per) @(negedge clk);
        if (tx_o !== 1'b1) framed = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        int t = 0;
        v = '0;
        while (v[6] !== 1'b1 && t < 20000) begin bus_rd(8'h54, v); t++; end
    endtask

    logic [31:0] rv;
    logic [7:0]  rb;
    bit          fr;
    bit          line_moved;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state
        check(tx_o === 1'b1, "R10 tx idle", tx_o, 1);
        check(rts_n_o === 1'b1, "R10 rts", rts_n_o, 1);
        bus_rd(8'h04, rv); check(rv == 0, "R10 enables", rv, 0);

        // R8: block off, writes ignored and reads zero
        bus_wr(8'h68, 32'd5);
        bus_wr(8'h50, 32'h2);
        check(rts_n_o === 1'b1, "R8 mcr ignored while off", rts_n_o, 1);
        bus_rd(8'h54, rv); check(rv == 0, "R8 read zero while off", rv, 0);
        bus_wr(8'h04, 32'h1);
        bus_rd(8'h68, rv); check(rv == 0, "R8 divisor kept", rv, 0);
        bus_rd(8'h60, rv); check(rv == 0, "R10 cntl", rv, 0);
        bus_rd(8'h54, rv); check(rv == 32'h60, "R5 empty status", rv, 32'h60);
        bus_rd(8'h40, rv); check(rv == 0, "R6 io reads zero", rv, 0);

        // R4: request-to-send polarity
        bus_wr(8'h50, 32'h2);
        check(rts_n_o === 1'b0, "R4 rts set", rts_n_o, 0);
        bus_wr(8'h50, 32'h0);
        check(rts_n_o === 1'b1, "R4 rts clear", rts_n_o, 1);

        // R9: interrupt enable / identify
        bus_wr(8'h44, 32'h2);
        bus_rd(8'h44, rv); check(rv == 2, "R9 ier readback", rv, 2);
        bus_rd(8'h48, rv); check(rv == 32'hC2, "R9 iir pending", rv, 32'hC2);
        bus_wr(8'h48, 32'h0);
        bus_rd(8'h48, rv); check(rv == 32'hC2, "R9 iir write ignored", rv, 32'hC2);
        bus_wr(8'h44, 32'h0);
        bus_rd(8'h48, rv); check(rv == 32'hC1, "R9 iir quiet", rv, 32'hC1);

        // R3 / R7: line control and control readback
        bus_wr(8'h4C, 32'h3);
        bus_rd(8'h4C, rv); check(rv == 1, "R3 lcr bit1 dropped", rv, 1);
        bus_wr(8'h60, 32'h3);
        bus_rd(8'h60, rv); check(rv == 3, "R7 cntl readback", rv, 3);
        bus_wr(8'h60, 32'h2);

        // R1: bit period sweep
        for (int d = 0; d < 4; d++) begin
            int len;
            bus_wr(8'h68, d);
            bus_rd(8'h68, rv); check(rv == d, "R1 divisor readback", rv, d);
            bus_wr(8'h40, 32'hFF);
            wait_low();
            len = 0;
            while (tx_o === 1'b0 && len < 1000) begin len++; @(negedge clk); end
            check(len == 8 * (d + 1), "R1 start bit length", len, 8 * (d + 1));
            wait_idle();
        end

        // R2: frame content sweep over divisors and patterns
        for (int d = 0; d < 3; d++) begin
            bus_wr(8'h68, d);
            for (int p = 0; p < 3; p++) begin
                logic [7:0] v;
                v = (p == 0) ? 8'hA5 : (p == 1) ? 8'h3C : 8'h81;
                bus_wr(8'h40, v);
                rx_frame(8, 8 * (d + 1), rb, fr);
                check(rb == v && fr, "R2 frame data", rb, v);
            end
            wait_idle();
        end

        // R5: status while a frame is on the line
        bus_wr(8'h68, 32'd1);
        bus_wr(8'h40, 32'h11);
        repeat (4) @(negedge clk);
        bus_rd(8'h54, rv); check(rv == 32'h20, "R5 busy status", rv, 32'h20);
        wait_idle();

        // R3: seven-bit mode (bit1 set, bit0 clear)
        bus_wr(8'h68, 32'd0);
        bus_wr(8'h4C, 32'h2);
        bus_wr(8'h40, 32'hD5);
        rx_frame(7, 8, rb, fr);
        check(rb == 8'h55 && fr, "R3 seven bit frame", rb, 8'h55);
        wait_idle();
        bus_wr(8'h4C, 32'h1);

        // R6 / R7: fill queue with transmitter off, overflow, then drain
        bus_wr(8'h60, 32'h1);
        for (int i = 0; i < 8; i++) begin
            bus_wr(8'h40, i * 17 + 3);
            if (i == 6) begin
                bus_rd(8'h54, rv); check(rv == 32'h20, "R5 space at seven", rv, 32'h20);
            end
        end
        bus_rd(8'h54, rv); check(rv == 32'h00, "R5 full status", rv, 0);
        bus_wr(8'h40, 32'hEE);
        line_moved = 1'b0;
        repeat (50) begin @(negedge clk); if (tx_o !== 1'b1) line_moved = 1'b1; end
        check(!line_moved, "R7 no frame while disabled", line_moved, 0);
        bus_wr(8'h60, 32'h2);
        for (int i = 0; i < 8; i++) begin
            rx_frame(8, 8, rb, fr);
            check(rb == 8'(i * 17 + 3) && fr, "R6 queue order", rb, 8'(i * 17 + 3));
        end
        wait_idle();
        line_moved = 1'b0;
        repeat (200) begin @(negedge clk); if (tx_o !== 1'b1) line_moved = 1'b1; end
        check(!line_moved, "R6 overflow byte dropped", line_moved, 0);

        // R8: freeze mid frame
        bus_wr(8'h68, 32'd3);
        bus_wr(8'h40, 32'h00);
        wait_low();
        repeat (10) @(negedge clk);
        bus_wr(8'h04, 32'h0);
        line_moved = 1'b0;
        repeat (100) begin @(negedge clk); if (tx_o !== 1'b0) line_moved = 1'b1; end
        check(!line_moved, "R8 line frozen", line_moved, 0);
        bus_wr(8'h68, 32'd7);
        bus_wr(8'h04, 32'h1);
        bus_rd(8'h68, rv); check(rv == 3, "R8 divisor locked", rv, 3);
        wait_idle();
        check(tx_o === 1'b1, "R2 idle high after frame", tx_o, 1);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule